// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the low-power mode selection for a small microcontroller core. Software reaches it through a special-function-register write bus at address 0x87, and it drives the gated clocks and the oscillator enable that put the chip into two sleep states. Idle halts the core clock while the peripheral clock keeps running, and any enabled interrupt request ends it. Stop drops the oscillator enable, so the clock stops and all synchronous logic freezes. Only a reset ends stop.

A missing-clock watchdog runs on a separate always-on reference clock. The reference domain sends a toggle into the main clock domain and waits for it to come back. Each completed round trip clears a timeout counter. If the counter reaches its limit while the watchdog is enabled, the block pulls the system reset low. That reset clears stop, the oscillator starts again, and the reset is released once the main clock is seen running.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with no write, `osc_en` is 1, `sys_rst_n` equals `rst_n`, and `cpu_clk` and `per_clk` each pulse once per `clk` period.
- R2: `sfr_rdata` is 0x00 at all times, including after a write of any value to address 0x87.
- R3: A write to address 0x87 with bit 0 set and bit 1 clear enters idle. From the `clk` period after the write edge, `cpu_clk` has no rising edge, and `per_clk` still pulses once per `clk` period.
- R4: Idle ends at the first `clk` edge where `irq_req & irq_en` is non-zero, and `cpu_clk` pulses again from the following period. A request whose enable bit is 0 leaves idle in place.
- R5: A write to address 0x87 with bit 1 set drops `osc_en` just after that write edge. From then on `cpu_clk` and `per_clk` stay low.
- R6: Stop ignores interrupt requests. It ends only on `rst_n` low or on a missing-clock reset, after which `osc_en` is 1 and both gated clocks run.
- R7: A single write that sets both bit 1 and bit 0 enters stop and not idle. After the reset that ends this stop, `cpu_clk` runs.
- R8: With `mcd_en` high and no `clk` activity for LIMIT = (REF_CLK_HZ/1e6)*TIMEOUT_US reference periods, `sys_rst_n` goes low. It returns high within a few reference periods of `clk` running again, and it never drops while `clk` runs.
- R9: With `mcd_en` low, a stopped `clk` never drives `sys_rst_n` low.
- R10: A write to any address other than 0x87, or a write to 0x87 with bits 1 and 0 both clear, changes neither clock nor `osc_en`.
- R11: The enables that gate `cpu_clk` and `per_clk` change only while `clk` is low, so no gated pulse is shorter than half a `clk` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| ref_clk | input | 1 | Always-on reference clock for the missing-clock watchdog |
| rst_n | input | 1 | External active-low asynchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (always zero) |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| mcd_en | input | 1 | Missing-clock watchdog enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk | output | 1 | Gated core clock |
| per_clk | output | 1 | Gated peripheral and timer clock |
| sys_rst_n | output | 1 | Active-low system reset (external or watchdog) |

## Verification
The assertions check the following on every cycle:
- Idle suppresses `cpu_clk` while `per_clk` keeps pulsing.
- An enabled request ends idle on the next edge.
- Stop and idle are never active together.
- Stop persists until a reset.
- Both gated clocks stay low once the oscillator is off.
- The watchdog never fires while it is disabled.
- The gate enables never move while `clk` is high.

Only the bench scenarios can show the following:
- The timing of the watchdog limit measured in reference periods.
- Recovery after the watchdog reset.
- Exact pulse counts on wake.
- The effect of foreign addresses and reserved-only writes.
- The always-zero read value.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter logic [7:0] SFR_ADDR   = 8'h87,
  parameter int         NUM_IRQ    = 8,
  parameter int         REF_CLK_HZ = 10_000_000,
  parameter int         TIMEOUT_US = 100
) (
  input  logic               clk,
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [7:0]         sfr_addr,
  input  logic               sfr_wr,
  input  logic [7:0]         sfr_wdata,
  output logic [7:0]         sfr_rdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               mcd_en,
  output logic               osc_en,
  output logic               cpu_clk,
  output logic               per_clk,
  output logic               sys_rst_n
);

  localparam int LIMIT    = (REF_CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int CW       = $clog2(LIMIT + 1);
  localparam int STOP_BIT = 1;
  localparam int IDLE_BIT = 0;

  logic          wr_hit, stop_req, idle_req, wake;
  logic          stop_q, idle_q;
  logic          cpu_gate, per_gate;
  logic [5:0]    rsvd_unused;

  logic          ack_s1, ack_s2;
  logic          en_s1, en_s2, back_s1, back_s2, req_t, fault, alive;
  logic [CW-1:0] cnt;

  assign wr_hit      = sfr_wr && (sfr_addr == SFR_ADDR);
  assign stop_req    = wr_hit && sfr_wdata[STOP_BIT];
  assign idle_req    = wr_hit && sfr_wdata[IDLE_BIT] && !sfr_wdata[STOP_BIT];
  assign wake        = |(irq_req & irq_en);
  assign rsvd_unused = sfr_wdata[7:2];
  assign sfr_rdata   = '0;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      stop_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      if (stop_req) stop_q <= 1'b1;
      idle_q <= idle_req || (idle_q && !wake && !stop_req);
    end
  end

  assign osc_en = !stop_q;

  always_latch begin
    if (!clk) begin
      cpu_gate = !(stop_q || idle_q);
      per_gate = !stop_q;
    end
  end

  assign cpu_clk = clk & cpu_gate;
  assign per_clk = clk & per_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= req_t;
      ack_s2 <= ack_s1;
    end
  end

  assign alive = (back_s2 == req_t);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1   <= 1'b0;
      en_s2   <= 1'b0;
      back_s1 <= 1'b0;
      back_s2 <= 1'b0;
      req_t   <= 1'b0;
      cnt     <= '0;
      fault   <= 1'b0;
    end else begin
      en_s1   <= mcd_en;
      en_s2   <= en_s1;
      back_s1 <= ack_s2;
      back_s2 <= back_s1;
      if (alive) req_t <= ~req_t;
      if (!en_s2 || alive)          cnt <= '0;
      else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
      if (alive)                    fault <= 1'b0;
      else if (cnt == CW'(LIMIT))   fault <= 1'b1;
    end
  end

  assign sys_rst_n = rst_n && !fault;

endmodule

// File: rtl/pwr_mode_ctrl_checker.sv
module pwr_mode_ctrl_checker #(
  parameter logic [7:0] SFR_ADDR = 8'h87,
  parameter int         NUM_IRQ  = 8
) (
  input logic               clk,
  input logic               ref_clk,
  input logic               rst_n,
  input logic               sys_rst_n,
  input logic               sfr_wr,
  input logic [7:0]         sfr_addr,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               mcd_en,
  input logic               osc_en,
  input logic               cpu_clk,
  input logic               per_clk,
  input logic               idle_q,
  input logic               stop_q,
  input logic               cpu_gate,
  input logic               per_gate
);

  assert_idle_gates_core_R3: assert property (@(negedge clk) disable iff (!sys_rst_n)
    (idle_q && $past(idle_q)) |-> (per_clk && !cpu_clk));

  assert_enabled_irq_wakes_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (idle_q && |(irq_req & irq_en) && !(sfr_wr && sfr_addr == SFR_ADDR)) |=> !idle_q);

  assert_osc_off_clocks_low_R5: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    (!osc_en && $past(!osc_en)) |-> (!cpu_clk && !per_clk));

  assert_stop_sticky_R6: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    $past(stop_q) |-> stop_q);

  assert_stop_excludes_idle_R7: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    stop_q |-> !idle_q);

  assert_no_watchdog_when_off_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mcd_en && $past(!mcd_en) && $past(!mcd_en, 2) && $past(!mcd_en, 3) && $past(!mcd_en, 4))
    |-> !$fell(sys_rst_n));

  always @(cpu_gate or per_gate) begin
    if (sys_rst_n === 1'b1) begin
      assert_gate_moves_low_R11: assert (clk !== 1'b1);
    end
  end

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_checker #(.SFR_ADDR(SFR_ADDR), .NUM_IRQ(NUM_IRQ)) i_chk (
  .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
  .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .irq_req(irq_req), .irq_en(irq_en),
  .mcd_en(mcd_en), .osc_en(osc_en), .cpu_clk(cpu_clk), .per_clk(per_clk),
  .idle_q(idle_q), .stop_q(stop_q), .cpu_gate(cpu_gate), .per_gate(per_gate)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

  localparam int NUM_IRQ = 8;
  localparam int REF_HZ  = 10_000_000;
  localparam int TMO_US  = 4;
  localparam int LIMIT   = (REF_HZ / 1_000_000) * TMO_US;

  logic               clk, ref_clk, rst_n;
  logic [7:0]         sfr_addr, sfr_wdata, sfr_rdata;
  logic               sfr_wr;
  logic [NUM_IRQ-1:0] irq_req, irq_en;
  logic               mcd_en, osc_en, cpu_clk, per_clk, sys_rst_n;

  int  n_chk = 0, n_bad = 0;
  int  cpu_pulses = 0, per_pulses = 0, short_pulses = 0;
  real t_cpu_rise = 0.0, t_per_rise = 0.0;

  pwr_mode_ctrl #(.SFR_ADDR(8'h87), .NUM_IRQ(NUM_IRQ), .REF_CLK_HZ(REF_HZ), .TIMEOUT_US(TMO_US))
    i_pwr_mode_ctrl (
      .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .irq_req(irq_req), .irq_en(irq_en), .mcd_en(mcd_en),
      .osc_en(osc_en), .cpu_clk(cpu_clk), .per_clk(per_clk), .sys_rst_n(sys_rst_n));

  // 200 MHz oscillator model: stops low while the enable is off
  initial begin
    clk = 1'b0;
    forever begin
      #2.5;
      if (osc_en === 1'b1 || clk) clk = ~clk;
    end
  end

  initial begin
    ref_clk = 1'b0;
    #1;
    forever #50 ref_clk = ~ref_clk;
  end

  always @(posedge cpu_clk) begin cpu_pulses++; t_cpu_rise = $realtime; end
  always @(posedge per_clk) begin per_pulses++; t_per_rise = $realtime; end
  always @(negedge cpu_clk) if ($realtime - t_cpu_rise < 2.4) short_pulses++;
  always @(negedge per_clk) if ($realtime - t_per_rise < 2.4) short_pulses++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic count_pulses(input int periods, output int dc, output int dp);
    int c0, p0;
    c0 = cpu_pulses;
    p0 = per_pulses;
    #(periods * 5);
    dc = cpu_pulses - c0;
    dp = per_pulses - p0;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr  = a;
    sfr_wdata = d;
    sfr_wr    = 1'b1;
    @(posedge clk);
    #1;
    sfr_wr = 1'b0;
  endtask

  task automatic ext_reset();
    rst_n = 1'b0;
    #250;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    int dc, dp;
    @(negedge clk); #1;
    chk(osc_en == 1'b1, "R1", "osc_en in reset", osc_en, 1);
    chk(sys_rst_n == 1'b0, "R1", "sys_rst_n in reset", sys_rst_n, 0);
    count_pulses(10, dc, dp);
    chk(dc == 10 && dp == 10, "R1", "clock pulses in reset", dc * 100 + dp, 1010);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(sys_rst_n == 1'b1, "R1", "sys_rst_n after release", sys_rst_n, 1);
    count_pulses(10, dc, dp);
    chk(dc == 10 && dp == 10, "R1", "clock pulses after release", dc * 100 + dp, 1010);
  endtask

  task automatic t_ignored_writes();
    int dc, dp;
    sfr_write(8'h86, 8'h01);
    sfr_write(8'h88, 8'h02);
    sfr_write(8'h87, 8'hFC);
    chk(sfr_rdata == 8'h00, "R2", "read after 0xFC write", sfr_rdata, 0);
    chk(osc_en == 1'b1, "R10", "osc_en after ignored writes", osc_en, 1);
    @(negedge clk);
    count_pulses(10, dc, dp);
    chk(dc == 10 && dp == 10, "R10", "clocks after ignored writes", dc * 100 + dp, 1010);
  endtask

  task automatic t_idle_and_wake();
    int dc, dp;
    irq_en = 8'h0F;
    sfr_write(8'h87, 8'h01);
    chk(sfr_rdata == 8'h00, "R2", "read in idle", sfr_rdata, 0);
    @(negedge clk);
    count_pulses(10, dc, dp);
    chk(dc == 0, "R3", "cpu pulses in idle", dc, 0);
    chk(dp == 10, "R3", "per pulses in idle", dp, 10);
    @(negedge clk);
    irq_req = 8'hF0;
    count_pulses(10, dc, dp);
    chk(dc == 0, "R4", "masked request keeps idle", dc, 0);
    @(negedge clk);
    irq_req = 8'h04;
    count_pulses(10, dc, dp);
    chk(dc == 9, "R4", "cpu pulses after wake", dc, 9);
    irq_req = '0;
  endtask

  task automatic t_stop_ext_reset();
    int dc, dp;
    sfr_write(8'h87, 8'h02);
    chk(osc_en == 1'b0, "R5", "osc_en after stop write", osc_en, 0);
    #20;
    count_pulses(40, dc, dp);
    chk(dc == 0 && dp == 0, "R5", "clocks in stop", dc * 100 + dp, 0);
    chk(sfr_rdata == 8'h00, "R2", "read in stop", sfr_rdata, 0);
    irq_req = 8'h01;
    #200;
    chk(osc_en == 1'b0, "R6", "irq does not end stop", osc_en, 0);
    irq_req = '0;
    ext_reset();
    chk(osc_en == 1'b1, "R6", "osc_en after reset", osc_en, 1);
    @(negedge clk);
    count_pulses(10, dc, dp);
    chk(dc == 10 && dp == 10, "R6", "clocks after reset", dc * 100 + dp, 1010);
  endtask

  task automatic t_both_bits();
    int dc, dp;
    sfr_write(8'h87, 8'h03);
    chk(osc_en == 1'b0, "R7", "stop wins over idle", osc_en, 0);
    #100;
    ext_reset();
    @(negedge clk);
    count_pulses(10, dc, dp);
    chk(dc == 10, "R7", "cpu runs after reset, idle not kept", dc, 10);
  endtask

  task automatic t_watchdog_fires();
    int lows, n, dc, dp;
    bit fired, back;
    mcd_en = 1'b1;
    lows = 0;
    for (int i = 0; i < 3 * LIMIT; i++) begin
      @(negedge ref_clk);
      if (!sys_rst_n) lows++;
    end
    chk(lows == 0, "R8", "no watchdog reset while clk runs", lows, 0);
    sfr_write(8'h87, 8'h02);
    fired = 1'b0;
    n = 0;
    for (int i = 1; i <= LIMIT + 20; i++) begin
      @(negedge ref_clk);
      if (!sys_rst_n) begin
        fired = 1'b1;
        n = i;
        break;
      end
    end
    chk(fired && n >= LIMIT - 6 && n <= LIMIT + 6, "R8", "watchdog delay in ref periods", n, LIMIT);
    back = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge ref_clk);
      if (sys_rst_n) begin
        back = 1'b1;
        break;
      end
    end
    chk(back, "R8", "watchdog reset released", back, 1);
    chk(osc_en == 1'b1, "R6", "osc_en after watchdog reset", osc_en, 1);
    @(negedge clk);
    count_pulses(10, dc, dp);
    chk(dc == 10 && dp == 10, "R6", "clocks after watchdog reset", dc * 100 + dp, 1010);
  endtask

  task automatic t_watchdog_off();
    int lows;
    mcd_en = 1'b0;
    repeat (6) @(negedge ref_clk);
    sfr_write(8'h87, 8'h02);
    lows = 0;
    for (int i = 0; i < 3 * LIMIT; i++) begin
      @(negedge ref_clk);
      if (!sys_rst_n) lows++;
    end
    chk(lows == 0, "R9", "no reset with watchdog off", lows, 0);
    chk(osc_en == 1'b0, "R9", "still in stop", osc_en, 0);
    ext_reset();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    sfr_addr  = '0;
    sfr_wdata = '0;
    sfr_wr    = 1'b0;
    irq_req   = '0;
    irq_en    = '0;
    mcd_en    = 1'b0;
    t_reset();
    t_ignored_writes();
    t_idle_and_wake();
    t_stop_ext_reset();
    t_both_bits();
    t_watchdog_fires();
    t_watchdog_off();
    chk(short_pulses == 0, "R11", "gated pulses shorter than half period", short_pulses, 0);
    finish_run();
  end

endmodule